// File: doc/BRIEF.md
# Body-Bias Calibration Sequencer

This block tunes one signed body-bias code for each submodule on a die, one submodule after another, after power-up. A calibration pulse starts the run. The sequencer sets every submodule's code to the most reverse value, which gives the lowest leakage. It then works through the submodules in index order. For the submodule under calibration it waits a chosen number of settle cycles and launches that submodule's built-in timing test. If the test fails, it moves the code one step toward forward bias and tests again.

A submodule keeps the first code at which its test passes. A submodule that still fails at the most forward code keeps that code and has its fail flag raised. When the last submodule is finished the done flag rises. The codes then stay frozen until the next calibration pulse.

Each step is one 32 mV increment. The code range of ±15 therefore spans roughly half a volt of reverse or forward bias.

Top module: `bias_cal_seq`

## Requirements
- R1: While reset is low, and after it is released, every bias code is 0, every fail flag is 0, `cal_done` is 0 and `test_start` is 0.
- R2: When `cal_start` is high at a clock edge while the block is idle, every bias code becomes -15 (5'b10001), every fail flag clears and `cal_done` drops, all at that same edge.
- R3: After the bias under test is applied or changed, `test_start` rises for exactly one cycle after `settle_cycles`+1 cycles.
- R4: When `test_done` is high with `test_pass` low and the current code is below +15, the code of the submodule under test rises by exactly one. The code changes at no other time, except on the start of a calibration.
- R5: When `test_done` is high with `test_pass` high, that submodule keeps its code and calibration moves on to the next index.
- R6: When a test fails at code +15, the code stays at +15, that submodule's fail flag is set, and calibration moves on.
- R7: Submodules are calibrated in index order from 0 to N_SUB-1, and `test_sel` shows the index under test.
- R8: After the last submodule is finished, `cal_done` is high and stays high. Codes and flags stay frozen, and no test is launched, until the next `cal_start`.
- R9: A `cal_start` pulse during a calibration has no effect on the sequence, the codes or the flags.
- R10: Submodule i's code is a 5-bit two's-complement value at `bias_codes[5i+4:5i]`, and it always stays within -15..+15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Calibration request pulse |
| settle_cycles | input | SETTLE_W | Wait count after a bias change |
| test_start | output | 1 | One-cycle launch of the built-in test |
| test_sel | output | IDX_W | Index of the submodule under test |
| test_done | input | 1 | Test completion strobe |
| test_pass | input | 1 | Test outcome, valid with `test_done` |
| bias_codes | output | N_SUB*CODE_W | Packed signed bias codes |
| cal_done | output | 1 | Calibration finished |
| fail_flags | output | N_SUB | Per-submodule no-pass flag |

## Verification
Three events can fall in the same cycle: a failing test result that arrives while the code is already at +15, a move to the last index, and the end of the calibration. The bench's test responder gives some submodules pass thresholds above +15, including the last index, so this collision occurs. The per-clock reference model then requires the code to hold at +15, the fail flag to be set and `cal_done` to rise, all at the same edge. The bench also raises `cal_start` in the same cycle that a test result arrives. The sequence must go on unchanged.

// File: rtl/bias_cal_seq.sv
module bias_cal_seq #(
  parameter int N_SUB    = 21,
  parameter int CODE_W   = 5,
  parameter int SETTLE_W = 8,
  parameter int IDX_W    = $clog2(N_SUB)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cal_start,
  input  logic [SETTLE_W-1:0]       settle_cycles,
  output logic                      test_start,
  output logic [IDX_W-1:0]          test_sel,
  input  logic                      test_done,
  input  logic                      test_pass,
  output logic [N_SUB*CODE_W-1:0]   bias_codes,
  output logic                      cal_done,
  output logic [N_SUB-1:0]          fail_flags
);
  localparam int CODE_MAX = (1 << (CODE_W-1)) - 1;
  localparam logic [CODE_W-1:0] C_TOP = CODE_MAX[CODE_W-1:0];
  localparam logic [CODE_W-1:0] C_BOT = ~C_TOP + 1'b1;
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(N_SUB-1);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_LAUNCH, S_WAIT} st_t;
  st_t                 st_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [CODE_W-1:0]   code_q [N_SUB];
  logic                done_q;
  logic [N_SUB-1:0]    fail_q;

  for (genvar g = 0; g < N_SUB; g++) begin : g_pack
    assign bias_codes[g*CODE_W +: CODE_W] = code_q[g];
  end

  wire at_top = (code_q[idx_q] == C_TOP);

  assign test_start = (st_q == S_LAUNCH);
  assign test_sel   = idx_q;
  assign cal_done   = done_q;
  assign fail_flags = fail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      fail_q <= '0;
      for (int i = 0; i < N_SUB; i++) code_q[i] <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cal_start) begin
          for (int i = 0; i < N_SUB; i++) code_q[i] <= C_BOT;
          fail_q <= '0;
          done_q <= 1'b0;
          idx_q  <= '0;
          cnt_q  <= '0;
          st_q   <= S_SETTLE;
        end
        S_SETTLE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == settle_cycles) st_q <= S_LAUNCH;
        end
        S_LAUNCH: st_q <= S_WAIT;
        S_WAIT: if (test_done) begin
          cnt_q <= '0;
          if (test_pass || at_top) begin
            if (!test_pass) fail_q[idx_q] <= 1'b1;
            if (idx_q == LAST) begin
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= S_SETTLE;
            end
          end else begin
            code_q[idx_q] <= code_q[idx_q] + 1'b1;
            st_q          <= S_SETTLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

module bias_cal_seq_chk #(
  parameter int N_SUB  = 21,
  parameter int CODE_W = 5,
  parameter int IDX_W  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cal_start,
  input logic                    test_start,
  input logic [IDX_W-1:0]        test_sel,
  input logic                    test_done,
  input logic [N_SUB*CODE_W-1:0] bias_codes,
  input logic                    cal_done,
  input logic [N_SUB-1:0]        fail_flags
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) test_start |=> !test_start); // R3
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) test_sel < IDX_W'(N_SUB)); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cal_done |-> !test_start); // R8
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (cal_done && !cal_start) |=> ($stable(bias_codes) && $stable(fail_flags))); // R8
  AST_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (!test_done && !cal_start) |=> $stable(bias_codes)); // R4
  for (genvar g = 0; g < N_SUB; g++) begin : g_rng
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) bias_codes[g*CODE_W +: CODE_W] != {1'b1, {(CODE_W-1){1'b0}}}); // R10
  end
endmodule

bind bias_cal_seq bias_cal_seq_chk #(.N_SUB(N_SUB), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .test_start(test_start),
  .test_sel(test_sel), .test_done(test_done), .bias_codes(bias_codes),
  .cal_done(cal_done), .fail_flags(fail_flags));

// File: tb/bias_cal_seq_test.sv
module bias_cal_seq_test;
  localparam int N = 21;
  localparam int CW = 5;
  localparam int SW = 8;
  localparam int IW = 5;

  logic clk = 1'b0, rst_n = 1'b0, cal_start = 1'b0, test_done = 1'b0, test_pass = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic test_start, cal_done;
  logic [IW-1:0] test_sel;
  logic [N*CW-1:0] bias_codes;
  logic [N-1:0] fail_flags;

  always #2 clk = ~clk;

  bias_cal_seq #(.N_SUB(N), .CODE_W(CW), .SETTLE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .settle_cycles(settle_cycles),
    .test_start(test_start), .test_sel(test_sel), .test_done(test_done),
    .test_pass(test_pass), .bias_codes(bias_codes), .cal_done(cal_done),
    .fail_flags(fail_flags));

  int total = 0, bad = 0;
  int thr[N];
  int lat = 1;

  // reference model
  int m_code[N];
  int m_fail[N];
  int m_done, m_busy, m_idx, m_left, m_phase; // phase: 1 settle, 2 launch, 3 wait

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_code[i]) begin m_code[i] = 0; m_fail[i] = 0; end
      m_done = 0; m_busy = 0; m_idx = 0; m_phase = 0; m_left = 0;
    end else if (!m_busy) begin
      if (cal_start) begin
        foreach (m_code[i]) begin m_code[i] = -15; m_fail[i] = 0; end
        m_done = 0; m_busy = 1; m_idx = 0; m_phase = 1; m_left = int'(settle_cycles);
      end
    end else if (m_phase == 1) begin
      if (m_left == 0) m_phase = 2; else m_left--;
    end else if (m_phase == 2) begin
      m_phase = 3;
    end else if (test_done) begin
      m_phase = 1; m_left = int'(settle_cycles);
      if (!test_pass && m_code[m_idx] < 15) m_code[m_idx]++;
      else begin
        if (!test_pass) m_fail[m_idx] = 1;
        if (m_idx == N-1) begin m_busy = 0; m_done = 1; m_phase = 0; end
        else m_idx++;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int code_of(int i);
    return int'($signed(bias_codes[i*CW +: CW]));
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(test_start == (m_busy == 1 && m_phase == 2), "R3 test_start", int'(test_start), int'(m_busy == 1 && m_phase == 2));
    if (m_busy == 1) chk(int'(test_sel) == m_idx, "R7 test_sel", int'(test_sel), m_idx);
    chk(int'(cal_done) == m_done, "R8 cal_done", int'(cal_done), m_done);
    for (int i = 0; i < N; i++) begin
      if (code_of(i) != m_code[i]) chk(1'b0, "R4 R5 R6 R10 bias code", code_of(i), m_code[i]);
      if (int'(fail_flags[i]) != m_fail[i]) chk(1'b0, "R6 fail flag", int'(fail_flags[i]), m_fail[i]);
    end
  end

  // test responder
  initial begin
    int pend;
    pend = -1;
    forever begin
      @(negedge clk);
      test_done = 1'b0;
      if (test_start) pend = lat;
      else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          test_done = 1'b1;
          test_pass = (code_of(int'(test_sel)) >= thr[test_sel]);
          pend = -1;
        end
      end
    end
  end

  task automatic run_cal(input int settle, input int mode, input bit poke);
    for (int i = 0; i < N; i++) thr[i] = (mode == 0) ? ((i*7) % 33) - 15 : ((i*11 + 5) % 33) - 15;
    thr[N-1] = 16;
    settle_cycles = SW'(settle);
    @(negedge clk); cal_start = 1'b1;
    @(negedge clk); cal_start = 1'b0;
    for (int i = 0; i < N; i++) chk(code_of(i) == -15, "R2 start code", code_of(i), -15);
    chk(fail_flags == '0 && !cal_done, "R2 flags cleared", int'(fail_flags), 0);
    if (poke) begin
      // R9: request coincides with a test result
      while (!test_done) @(negedge clk);
      cal_start = 1'b1;
      @(negedge clk); cal_start = 1'b0;
      repeat (40) @(negedge clk);
      cal_start = 1'b1;
      @(negedge clk); cal_start = 1'b0;
    end
    while (!cal_done) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      int e;
      e = (thr[i] < -15) ? -15 : (thr[i] > 15 ? 15 : thr[i]);
      chk(code_of(i) == e, "R5 R6 final code", code_of(i), e);
      chk(int'(fail_flags[i]) == int'(thr[i] > 15), "R6 final flag", int'(fail_flags[i]), int'(thr[i] > 15));
    end
    repeat (10) @(negedge clk);
    chk(cal_done == 1'b1, "R8 done held", int'(cal_done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bias_codes == '0 && fail_flags == '0 && !cal_done && !test_start, "R1 reset state", int'(cal_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bias_codes == '0 && !test_start, "R1 after release", int'(test_start), 0);
    lat = 1; run_cal(0, 0, 1'b0);
    lat = 3; run_cal(3, 1, 1'b1);
    lat = 2; run_cal(1, 0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R8 act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule